// File: doc/BRIEF.md
# Programmable ATA PIO Cycle Sequencer

This block runs programmed-I/O register and data transfers on one parallel ATA-style channel that has two drives attached. A host issues one request at a time on a simple request port. The request carries the drive number, a command-versus-data flag, a register-block select, a 3-bit register address, the direction and the write data. The block steps the channel through three phases. In address setup the address and chip select settle. In the strobe phase the read or write strobe is driven low. In recovery the strobe is released while the address and chip select are held. When recovery ends, a one-cycle done pulse returns the read data and an error flag.

Every phase length is a 4-bit count in clock cycles, taken from a timing set. Data transfers use the addressed drive's own data timing set. A format input sets how command transfers are timed. When it is clear, one shared command set serves both drives; software loads it with the slower drive's timing. When it is set, each drive has its own command set. The ready input from the drive is sampled once, at the end of the programmed strobe length. If the drive is not ready there, the strobe is stretched until it becomes ready. If it stays not ready, the stretch is cut off after a programmable limit. A separate register drives the drive-reset line at whatever level software writes to it.

Top module: `ata_pio_seq`

## Requirements
- R1: An accepted request gives `Ns` setup cycles, then `Na` strobe cycles, then `Nr` recovery cycles, and `rsp_done` is high for exactly one cycle right after the last recovery cycle. During setup and recovery both strobes are high and a chip select is low. A timing word holds setup in bits [3:0], strobe in bits [7:4] and recovery in bits [11:8].
- R2: A phase count of 0 gives a phase of one cycle.
- R3: `ata_iordy` is sampled in the last programmed strobe cycle. If it is high there, the strobe lasts exactly `Na` cycles.
- R4: If `ata_iordy` is low at that sample point, the strobe continues up to and including the first cycle in which `ata_iordy` is high. `rsp_err` stays low in that case.
- R5: If `ata_iordy` is still low after `cfg_tmo` extra strobe cycles (0 counts as 1), the strobe ends after `Na + cfg_tmo` cycles. `rsp_err` is then high with the done pulse.
- R6: Data transfers (`req_cmd`=0) use the addressed drive's data timing set. Drive n uses bits [12n+11:12n] of `cfg_dat_tim`.
- R7: Command transfers (`req_cmd`=1) use `cfg_shared_cmd` when `cfg_sep_fmt`=0. They use bits [12n+11:12n] of `cfg_cmd_tim` for drive n when `cfg_sep_fmt`=1.
- R8: For a read, `ata_din` is captured on the edge that releases the strobe. It is presented on `rsp_rdata` with the done pulse.
- R9: For a write, `ata_diow_n` is the strobe. `ata_dout` carries the request's write data and `ata_dout_en` is high from setup through recovery.
- R10: `req_ready` is high only while idle. A `req_valid` seen while busy is ignored: no extra transfer occurs and the address lines of the running transfer do not change.
- R11: `ata_rst_n` is high after reset. A cycle with `drst_we`=1 sets it to `drst_val` from the next cycle on.
- R12: `req_blk`=0 drives `ata_cs_n`=2'b10 and `req_blk`=1 drives 2'b01, from setup through recovery. `ata_cs_n` is 2'b11 when idle.
- R13: `ata_dior_n` and `ata_diow_n` are never low together, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sep_fmt | input | 1 | 1: per-drive command timing; 0: shared command timing |
| cfg_shared_cmd | input | 12 | Shared command timing word |
| cfg_cmd_tim | input | 12*NUM_DRV | Per-drive command timing words |
| cfg_dat_tim | input | 12*NUM_DRV | Per-drive data timing words |
| cfg_tmo | input | TMO_W | Limit on extra strobe cycles while waiting for ready |
| drst_we | input | 1 | Write strobe for the drive-reset level |
| drst_val | input | 1 | Level to write to the drive-reset output |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_drive | input | DRV_W | Target drive |
| req_cmd | input | 1 | 1 command transfer, 0 data transfer |
| req_blk | input | 1 | Register block select (chooses chip select) |
| req_addr | input | 3 | Register address |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Ready timeout flag, valid with rsp_done |
| rsp_rdata | output | DW | Read data |
| ata_addr | output | 3 | Channel address lines |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_dior_n | output | 1 | Active-low read strobe |
| ata_diow_n | output | 1 | Active-low write strobe |
| ata_dout | output | DW | Write data to the channel |
| ata_dout_en | output | 1 | Data bus drive enable |
| ata_din | input | DW | Read data from the channel |
| ata_iordy | input | 1 | Drive ready |
| ata_rst_n | output | 1 | Drive reset line |

## Verification
A phase counter loaded from the wrong timing set, or a wrong format choice, changes the number of cycles in setup, strobe or recovery, and the bench counts those cycles at the pins in the same transfer. A faulty ready sample or wait counter changes the strobe length or the error flag at the first stalled transfer. A wrong capture edge shows as bad read data at the next done pulse. An idle/busy fault shows as an extra or missing done pulse, or as address lines that change in the middle of a transfer.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int FLD_W = 4;

    typedef struct packed {
        logic [FLD_W-1:0] recov;
        logic [FLD_W-1:0] active;
        logic [FLD_W-1:0] setup;
    } pio_tim_t;

    localparam int TIM_W = $bits(pio_tim_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_WAIT,
        PH_RECOV
    } phase_t;

    // Counter preload for a phase of n cycles; zero behaves as one cycle.
    function automatic logic [FLD_W-1:0] span_load(input logic [FLD_W-1:0] n);
        return (n == '0) ? '0 : n - FLD_W'(1);
    endfunction

endpackage

// File: rtl/ata_pio_timsel.sv
module ata_pio_timsel
    import ata_pio_pkg::*;
#(
    parameter int NUM_DRV = 2,
    parameter int DRV_W   = 1
) (
    input  logic                     sep_fmt,
    input  pio_tim_t                 shared_cmd,
    input  logic [NUM_DRV*TIM_W-1:0] cmd_flat,
    input  logic [NUM_DRV*TIM_W-1:0] dat_flat,
    input  logic [DRV_W-1:0]         drive,
    input  logic                     is_cmd,
    output pio_tim_t                 sel
);

    pio_tim_t cmd_set [NUM_DRV];
    pio_tim_t dat_set [NUM_DRV];

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_unpack
        assign cmd_set[g] = cmd_flat[g*TIM_W +: TIM_W];
        assign dat_set[g] = dat_flat[g*TIM_W +: TIM_W];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_DRV; i++) begin
            if (drive == DRV_W'(i)) begin
                if (is_cmd) begin
                    sel = sep_fmt ? cmd_set[i] : shared_cmd;
                end else begin
                    sel = dat_set[i];
                end
            end
        end
    end

endmodule

// File: rtl/ata_pio_rstctl.sv
module ata_pio_rstctl (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic val,
    output logic drv_rst_n
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b1;
        end else if (we) begin
            level_q <= val;
        end
    end

    assign drv_rst_n = level_q;

    // R11: reset leaves the drive-reset line released
    a_r11_reset_high: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> drv_rst_n);

    // R11: a write takes effect on the next cycle
    a_r11_write_level: assert property (@(posedge clk) disable iff (rst)
        we |=> (drv_rst_n == $past(val)));

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int DW    = 16,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  pio_tim_t         tim,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             write,
    input  logic             blk,
    input  logic [2:0]       addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    din,
    input  logic             iordy,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [DW-1:0]    rdata,
    output logic [2:0]       bus_addr,
    output logic [1:0]       cs_n,
    output logic             dior_n,
    output logic             diow_n,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);

    localparam int WC_W = TMO_W + 1;

    phase_t           ph;
    logic [FLD_W-1:0] cnt;
    logic [TMO_W-1:0] wcnt;
    pio_tim_t         tim_q;
    logic [TMO_W-1:0] tmo_q;
    logic             wr_q;
    logic             blk_q;
    logic [2:0]       addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             done_q;
    logic             err_q;

    logic [WC_W-1:0]  tmo_eff;
    logic             tmo_last;
    logic             strobing;

    assign tmo_eff  = (tmo_q == '0) ? WC_W'(1) : {1'b0, tmo_q};
    assign tmo_last = ({1'b0, wcnt} + WC_W'(1)) >= tmo_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            wcnt    <= '0;
            tim_q   <= '0;
            tmo_q   <= '0;
            wr_q    <= 1'b0;
            blk_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        tim_q   <= tim;
                        tmo_q   <= tmo_lim;
                        wr_q    <= write;
                        blk_q   <= blk;
                        addr_q  <= addr;
                        wdata_q <= wdata;
                        err_q   <= 1'b0;
                        cnt     <= span_load(tim.setup);
                        ph      <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt <= span_load(tim_q.active);
                        ph  <= PH_STROBE;
                    end else begin
                        cnt <= cnt - FLD_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - FLD_W'(1);
                    end else if (iordy) begin
                        if (!wr_q) rdata_q <= din;
                        cnt <= span_load(tim_q.recov);
                        ph  <= PH_RECOV;
                    end else begin
                        wcnt <= '0;
                        ph   <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (iordy || tmo_last) begin
                        if (!wr_q) rdata_q <= din;
                        err_q <= !iordy;
                        cnt   <= span_load(tim_q.recov);
                        ph    <= PH_RECOV;
                    end else begin
                        wcnt <= wcnt + TMO_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt == '0) begin
                        done_q <= 1'b1;
                        ph     <= PH_IDLE;
                    end else begin
                        cnt <= cnt - FLD_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (ph != PH_IDLE);
    assign strobing = (ph == PH_STROBE) || (ph == PH_WAIT);
    assign done     = done_q;
    assign err      = done_q & err_q;
    assign rdata    = rdata_q;
    assign bus_addr = addr_q;
    assign cs_n     = busy ? (blk_q ? 2'b01 : 2'b10) : 2'b11;
    assign dior_n   = !(strobing && !wr_q);
    assign diow_n   = !(strobing && wr_q);
    assign dout     = wdata_q;
    assign dout_en  = busy && wr_q;

    // R1: the strobe phase is entered only from address setup
    a_r1_setup_first: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STROBE && $past(ph) != PH_STROBE) |-> ($past(ph) == PH_SETUP));

    // R1: done pulse lasts one cycle
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R3: a wait is entered only when ready was low at the sample point
    a_r3_no_stretch: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == PH_STROBE && ph == PH_WAIT) |-> !$past(iordy));

    // R4 / R5: leaving the wait needs ready or a timeout flag
    a_r4_wait_exit: assert property (@(posedge clk) disable iff (rst)
        ($past(ph) == PH_WAIT && ph == PH_RECOV) |-> ($past(iordy) || err_q));

    // R5: an error is only reported after a wait
    a_r5_err_needs_wait: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_SETUP) |-> !err_q);

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int  NUM_DRV = 2,
    parameter int  DW      = 16,
    parameter int  TMO_W   = 8,
    localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_sep_fmt,
    input  logic [TIM_W-1:0]         cfg_shared_cmd,
    input  logic [NUM_DRV*TIM_W-1:0] cfg_cmd_tim,
    input  logic [NUM_DRV*TIM_W-1:0] cfg_dat_tim,
    input  logic [TMO_W-1:0]         cfg_tmo,
    input  logic                     drst_we,
    input  logic                     drst_val,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [DRV_W-1:0]         req_drive,
    input  logic                     req_cmd,
    input  logic                     req_blk,
    input  logic [2:0]               req_addr,
    input  logic                     req_write,
    input  logic [DW-1:0]            req_wdata,
    output logic                     rsp_done,
    output logic                     rsp_err,
    output logic [DW-1:0]            rsp_rdata,
    output logic [2:0]               ata_addr,
    output logic [1:0]               ata_cs_n,
    output logic                     ata_dior_n,
    output logic                     ata_diow_n,
    output logic [DW-1:0]            ata_dout,
    output logic                     ata_dout_en,
    input  logic [DW-1:0]            ata_din,
    input  logic                     ata_iordy,
    output logic                     ata_rst_n
);

    pio_tim_t tim_sel;
    logic     busy;
    logic     start;

    assign req_ready = !busy;
    assign start     = req_valid && !busy;

    ata_pio_timsel #(
        .NUM_DRV (NUM_DRV),
        .DRV_W   (DRV_W)
    ) i_timsel (
        .sep_fmt    (cfg_sep_fmt),
        .shared_cmd (pio_tim_t'(cfg_shared_cmd)),
        .cmd_flat   (cfg_cmd_tim),
        .dat_flat   (cfg_dat_tim),
        .drive      (req_drive),
        .is_cmd     (req_cmd),
        .sel        (tim_sel)
    );

    ata_pio_engine #(
        .DW    (DW),
        .TMO_W (TMO_W)
    ) i_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tim      (tim_sel),
        .tmo_lim  (cfg_tmo),
        .write    (req_write),
        .blk      (req_blk),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .din      (ata_din),
        .iordy    (ata_iordy),
        .busy     (busy),
        .done     (rsp_done),
        .err      (rsp_err),
        .rdata    (rsp_rdata),
        .bus_addr (ata_addr),
        .cs_n     (ata_cs_n),
        .dior_n   (ata_dior_n),
        .diow_n   (ata_diow_n),
        .dout     (ata_dout),
        .dout_en  (ata_dout_en)
    );

    ata_pio_rstctl i_rstctl (
        .clk       (clk),
        .rst       (rst),
        .we        (drst_we),
        .val       (drst_val),
        .drv_rst_n (ata_rst_n)
    );

    // R10: address lines hold while a transfer runs
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(ata_addr));

    // R13: strobes are exclusive and qualified by a chip select
    a_r13_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));
    a_r13_strobe_cs: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> (ata_cs_n != 2'b11));

endmodule

// File: tb/test_ata_pio_seq.sv
`timescale 1ns/1ps
module test_ata_pio_seq;

    localparam int NUM_DRV = 2;
    localparam int DW      = 16;
    localparam int TMO_W   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        cfg_sep_fmt;
    logic [11:0] b_shared;
    logic [11:0] b_cmd [2];
    logic [11:0] b_dat [2];
    logic [TMO_W-1:0] cfg_tmo;
    logic        drst_we, drst_val;
    logic        req_valid, req_ready, req_drive, req_cmd, req_blk, req_write;
    logic [2:0]  req_addr;
    logic [DW-1:0] req_wdata;
    logic        rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_dior_n, ata_diow_n, ata_dout_en, ata_rst_n;
    logic [DW-1:0] ata_dout, ata_din;
    logic        ata_iordy;

    i_ata_pio_seq_wrap: begin end

    ata_pio_seq #(.NUM_DRV(NUM_DRV), .DW(DW), .TMO_W(TMO_W)) i_ata_pio_seq (
        .clk(clk), .rst(rst),
        .cfg_sep_fmt(cfg_sep_fmt), .cfg_shared_cmd(b_shared),
        .cfg_cmd_tim({b_cmd[1], b_cmd[0]}), .cfg_dat_tim({b_dat[1], b_dat[0]}),
        .cfg_tmo(cfg_tmo), .drst_we(drst_we), .drst_val(drst_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_drive(req_drive),
        .req_cmd(req_cmd), .req_blk(req_blk), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ata_addr(ata_addr), .ata_cs_n(ata_cs_n), .ata_dior_n(ata_dior_n),
        .ata_diow_n(ata_diow_n), .ata_dout(ata_dout), .ata_dout_en(ata_dout_en),
        .ata_din(ata_din), .ata_iordy(ata_iordy), .ata_rst_n(ata_rst_n)
    );

    typedef struct {
        int          s, a, r;
        bit          err, rd;
        logic [15:0] rdata, wdata;
        logic [2:0]  addr;
        logic [1:0]  cs;
        string       tag;
    } exp_t;

    exp_t exp_q [$];
    int n_chk = 0, n_fail = 0, n_push = 0, n_done = 0;
    int hold_low = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int expv);
        chk(act == expv, tag, act, expv);
    endtask

    function automatic int eff(input logic [3:0] n);
        return (n == 0) ? 1 : int'(n);
    endfunction

    // Driver: compute expectation, push it, then issue the request.
    task automatic xfer(input int drv, input bit cmd, input bit blk, input int addr,
                        input bit wr, input logic [15:0] wd, input logic [15:0] din,
                        input int hl, input string tag);
        exp_t e;
        logic [11:0] t;
        int na, tm;
        t = cmd ? (cfg_sep_fmt ? b_cmd[drv] : b_shared) : b_dat[drv];
        na = eff(t[7:4]);
        tm = (cfg_tmo == 0) ? 1 : int'(cfg_tmo);
        e.s = eff(t[3:0]);
        e.r = eff(t[11:8]);
        if (hl < na) begin e.a = na; e.err = 0; end
        else if (hl < na + tm) begin e.a = hl + 1; e.err = 0; end
        else begin e.a = na + tm; e.err = 1; end
        e.rd = !wr; e.rdata = din; e.wdata = wd; e.addr = 3'(addr);
        e.cs = blk ? 2'b01 : 2'b10; e.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        n_push++;
        hold_low = hl; ata_din = din;
        req_drive = drv[0]; req_cmd = cmd; req_blk = blk; req_addr = 3'(addr);
        req_write = wr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and device model, all sampled at the falling edge.
    int ms = 0, ma = 0, mr = 0, scyc = 0;
    bit seen = 0, dout_bad = 0;
    logic [2:0] m_addr;
    logic [1:0] m_cs;
    logic [15:0] m_dout;
    always @(negedge clk) begin
        if (!rst) begin
            bit strobe, csa;
            strobe = !ata_dior_n || !ata_diow_n;
            csa = (ata_cs_n != 2'b11);
            if (strobe) begin
                scyc++;
                ata_iordy = (scyc > hold_low);
                ma++; seen = 1;
                m_addr = ata_addr; m_cs = ata_cs_n; m_dout = ata_dout;
                if (!ata_diow_n && !ata_dout_en) dout_bad = 1;
            end else begin
                scyc = 0;
                ata_iordy = 1'b1;
                if (csa && !seen) ms++;
                if (csa && seen) mr++;
            end
            if (rsp_done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    chk(0, "R10 spurious transfer completed", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk_eq({"R1 setup cycles ", e.tag}, ms, e.s);
                    chk_eq({"R3/R4 strobe cycles ", e.tag}, ma, e.a);
                    chk_eq({"R1 recovery cycles ", e.tag}, mr, e.r);
                    chk_eq({"R5 error flag ", e.tag}, int'(rsp_err), int'(e.err));
                    chk_eq({"R10 address ", e.tag}, int'(m_addr), int'(e.addr));
                    chk_eq({"R12 chip select ", e.tag}, int'(m_cs), int'(e.cs));
                    if (e.rd) chk_eq({"R8 read data ", e.tag}, int'(rsp_rdata), int'(e.rdata));
                    else begin
                        chk_eq({"R9 write data ", e.tag}, int'(m_dout), int'(e.wdata));
                        chk_eq({"R9 data enable ", e.tag}, int'(dout_bad), 0);
                    end
                end
                ms = 0; ma = 0; mr = 0; seen = 0; dout_bad = 0;
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        cfg_sep_fmt = 0; b_shared = 12'h454; b_cmd[0] = 12'h111; b_cmd[1] = 12'h122;
        b_dat[0] = 12'h232; b_dat[1] = 12'h341; cfg_tmo = 8'd10;
        drst_we = 0; drst_val = 0; req_valid = 0; req_drive = 0; req_cmd = 0;
        req_blk = 0; req_addr = 0; req_write = 0; req_wdata = 0;
        ata_din = 16'h0; ata_iordy = 1'b1;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R10 ready after reset", int'(req_ready), 1);
        chk_eq("R12 chip selects idle", int'(ata_cs_n), 3);
        chk_eq("R13 strobes idle", int'({ata_dior_n, ata_diow_n}), 3);
        chk_eq("R1 no done after reset", int'(rsp_done), 0);
        chk_eq("R11 drive reset high after reset", int'(ata_rst_n), 1);

        // R11: software level control
        drst_we = 1; drst_val = 0; @(negedge clk); drst_we = 0;
        chk_eq("R11 drive reset driven low", int'(ata_rst_n), 0);
        @(negedge clk);
        chk_eq("R11 drive reset holds", int'(ata_rst_n), 0);
        drst_we = 1; drst_val = 1; @(negedge clk); drst_we = 0;
        chk_eq("R11 drive reset driven high", int'(ata_rst_n), 1);

        // R1 R6 R8: data read, drive 0
        xfer(0, 0, 0, 0, 0, 16'h0, 16'hA5A5, 0, "T1");
        // R6 R9: data write, drive 1
        xfer(1, 0, 0, 0, 1, 16'h1234, 16'h0, 0, "T2");
        // R7: shared command timing
        xfer(1, 1, 0, 7, 0, 16'h0, 16'h00C3, 0, "T3");
        // R7: per-drive command timing
        xfer(1, 1, 0, 3, 0, 16'h0, 16'h5A5A, 0, "T4");
        cfg_sep_fmt = 1;
        xfer(1, 1, 0, 3, 0, 16'h0, 16'h5A5B, 0, "T4b");
        // R12: control block write
        xfer(0, 1, 1, 6, 1, 16'hBEEF, 16'h0, 0, "T5");
        // R2: zero counts
        b_dat[0] = 12'h000;
        xfer(0, 0, 0, 1, 0, 16'h0, 16'h0F0F, 0, "T6");
        b_dat[0] = 12'h232;
        // R3: ready low before the sample point only
        xfer(0, 0, 0, 2, 0, 16'h0, 16'h1111, 2, "T7");
        // R4: stretch
        xfer(0, 0, 0, 2, 0, 16'h0, 16'h2222, 6, "T8");
        // R5: timeout
        cfg_tmo = 8'd4;
        xfer(0, 0, 0, 5, 0, 16'h0, 16'h3333, 50, "T9");
        // R10: request while busy is ignored
        @(negedge clk);
        chk_eq("R10 busy during transfer", int'(req_ready), 0);
        req_valid = 1; req_addr = 3'd7; req_blk = 1; req_write = 1;
        repeat (2) @(negedge clk);
        req_valid = 0;
        // R5: zero limit counts as one
        cfg_tmo = 8'd0;
        xfer(0, 0, 0, 4, 0, 16'h0, 16'h4444, 50, "T10");
        cfg_tmo = 8'd10;
        // back-to-back writes
        xfer(1, 0, 1, 0, 1, 16'h0001, 16'h0, 0, "T11a");
        xfer(1, 0, 1, 0, 1, 16'h8002, 16'h0, 0, "T11b");
        xfer(1, 0, 1, 1, 1, 16'h7FF3, 16'h0, 0, "T11c");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk_eq("R10 transfers completed equal requests", n_done, n_push);
        summary();
        $finish;
    end

endmodule